// File: doc/BRIEF.md
# Low-Power Sequencing Controller

This block steps a chip into and out of a low-power condition. Software raises a sleep request while the chip is running. The controller then asks the io, usb and main clock domains to stop their clocks. It waits until those clocks confirm that they are gated, and only then enters one of two sleeping states. A deep-sleep select, sampled when the request is accepted, picks which sleeping state it enters.

The chip leaves sleep when any wakeup source fires. The sources are an always-on timer, a system-reset controller and the pad multiplexer. On wakeup the controller passes through a fast-wake state, releases the clock-gate requests, waits until the clocks report that they run again, and returns to active operation.

A reset event from the reset manager sends the controller back to its reset state from any state. Every change of state is flagged by a one-cycle pulse.

Top module: `lpm_seq_top`

## Requirements
- R1: While rst_ni is low, pwrState reads 0 (reset state), gateReq is all zero and stateChg is 0. On the first clock edge after rst_ni rises, pwrState becomes 1 (active). State codes: 0 reset, 1 active, 2 request, 3 low power, 4 deep sleep, 5 fast wake.
- R2: In the active state, lpReq high at a clock edge moves the state to 2 at that edge. gateReq is all ones from the same cycle. gateReq bit 0 is io, bit 1 is usb and bit 2 is main.
- R3: State 2 holds while gateAck is 0. On an edge with gateAck high it moves to 3 if deepSel was low when the request was accepted, and to 4 if it was high.
- R4: deepSel is sampled only on the edge where the request is accepted. Changing it afterwards does not change which sleeping state is entered.
- R5: States 3 and 4 hold, with gateReq all ones, until any bit of wakeSrc is high. wakeSrc bit 0 is the timer, bit 1 is the reset controller and bit 2 is the pad multiplexer. Each bit alone is enough to wake.
- R6: A wakeup moves the state to 5 at the next edge, and gateReq reads all zero from that cycle. State 5 holds while gateAck is 1 and moves to 1 on an edge with gateAck low.
- R7: stateChg is high in exactly the first cycle in which pwrState shows a new value, and low in all other cycles.
- R8: rstEvt high at an edge forces the state to 0 with gateReq all zero, from any state. The next edge with rstEvt low moves the state to 1.
- R9: lpReq has no effect in any state other than active.
- R10: wakeSrc has no effect outside states 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lpReq | input | 1 | Software low-power request |
| deepSel | input | 1 | Selects deep sleep when the request is accepted |
| wakeSrc | input | NUM_WAKE | Wakeup sources: timer, reset controller, pad multiplexer |
| gateAck | input | 1 | High when all requested clock domains are gated |
| rstEvt | input | 1 | Reset event from the reset manager |
| pwrState | output | 3 | Current state code |
| stateChg | output | 1 | One-cycle pulse on each state change |
| gateReq | output | NUM_DOM | Per-domain clock-gate requests |

## Verification
The bench holds gateAck at its old level for several cycles, both in the request state and in fast wake. A design that did not wait for the handshake would sleep with clocks still running, or would resume before they restart. deepSel is flipped after the request is accepted. A design that sampled it late would enter the wrong sleeping state. The bench also sends lpReq and wakeSrc in states where they must be ignored, and rstEvt in the middle of a sleep sequence. A design that got these wrong would leave the sequence, would keep gate requests asserted after reset, or would miss or double the change pulse.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    PsReset    = 3'd0,
    PsActive   = 3'd1,
    PsLpReq    = 3'd2,
    PsLowPwr   = 3'd3,
    PsDeepSlp  = 3'd4,
    PsFastWake = 3'd5
  } pwrState_e;

  typedef struct packed {
    logic stateChg;
    logic gateSet;
    logic gateClr;
  } ctrlStrobe_t;
endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        lpReq,
  input  logic        deepSel,
  input  logic        wakeAny,
  input  logic        gateAck,
  input  logic        rstEvt,
  output pwrState_e   stateQ,
  output ctrlStrobe_t strobe
);
  pwrState_e stateD;
  logic deepQ;

  always_comb begin
    stateD = stateQ;
    if (rstEvt) begin
      stateD = PsReset;
    end else begin
      unique case (stateQ)
        PsReset:    stateD = PsActive;
        PsActive:   if (lpReq) stateD = PsLpReq;
        PsLpReq:    if (gateAck) stateD = deepQ ? PsDeepSlp : PsLowPwr;
        PsLowPwr,
        PsDeepSlp:  if (wakeAny) stateD = PsFastWake;
        PsFastWake: if (!gateAck) stateD = PsActive;
        default:    stateD = PsReset;
      endcase
    end
  end

  always_comb begin
    strobe.stateChg = (stateD != stateQ);
    strobe.gateSet  = strobe.stateChg && (stateD == PsLpReq);
    strobe.gateClr  = strobe.stateChg && ((stateD == PsFastWake) || (stateD == PsReset));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stateQ <= PsReset;
      deepQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == PsActive && lpReq && !rstEvt) deepQ <= deepSel;
    end
  end
endmodule

// File: rtl/lpm_gate.sv
module lpm_gate
  import lpm_pkg::*;
#(
  parameter int NUM_DOM  = 3,
  parameter int NUM_WAKE = 3
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  ctrlStrobe_t         strobe,
  input  logic [NUM_WAKE-1:0] wakeSrc,
  output logic                wakeAny,
  output logic                chgPulse,
  output logic [NUM_DOM-1:0]  gateReq
);
  assign wakeAny = |wakeSrc;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)              gateReq[d] <= 1'b0;
      else if (strobe.gateClr)  gateReq[d] <= 1'b0;
      else if (strobe.gateSet)  gateReq[d] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chgPulse <= 1'b0;
    else         chgPulse <= strobe.stateChg;
  end
endmodule

// File: rtl/lpm_seq_top.sv
module lpm_seq_top
  import lpm_pkg::*;
#(
  parameter int NUM_WAKE = 3,
  parameter int NUM_DOM  = 3
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                lpReq,
  input  logic                deepSel,
  input  logic [NUM_WAKE-1:0] wakeSrc,
  input  logic                gateAck,
  input  logic                rstEvt,
  output logic [2:0]          pwrState,
  output logic                stateChg,
  output logic [NUM_DOM-1:0]  gateReq
);
  pwrState_e   stateQ;
  ctrlStrobe_t strobe;
  logic        wakeAny;

  lpm_ctrl ctrl_i (
    .clk(clk), .rst_ni(rst_ni), .lpReq(lpReq), .deepSel(deepSel),
    .wakeAny(wakeAny), .gateAck(gateAck), .rstEvt(rstEvt),
    .stateQ(stateQ), .strobe(strobe)
  );

  lpm_gate #(.NUM_DOM(NUM_DOM), .NUM_WAKE(NUM_WAKE)) gate_i (
    .clk(clk), .rst_ni(rst_ni), .strobe(strobe), .wakeSrc(wakeSrc),
    .wakeAny(wakeAny), .chgPulse(stateChg), .gateReq(gateReq)
  );

  assign pwrState = stateQ;
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk #(
  parameter int NUM_WAKE = 3,
  parameter int NUM_DOM  = 3
) (
  input logic                clk,
  input logic                rst_ni,
  input logic                lpReq,
  input logic [NUM_WAKE-1:0] wakeSrc,
  input logic                gateAck,
  input logic                rstEvt,
  input logic [2:0]          pwrState,
  input logic                stateChg,
  input logic [NUM_DOM-1:0]  gateReq
);
  localparam logic [2:0] S_RST = 3'd0, S_ACT = 3'd1, S_REQ = 3'd2,
                         S_LOW = 3'd3, S_DEEP = 3'd4, S_FW = 3'd5;

  p_gated_sleep_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (pwrState == S_LOW || pwrState == S_DEEP) |-> (gateReq == '1));

  p_ungated_active_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (pwrState == S_ACT || pwrState == S_FW) |-> (gateReq == '0));

  p_pulse_on_change_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    stateChg |-> (pwrState != $past(pwrState)));

  p_change_has_pulse_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (pwrState != $past(pwrState)) |-> stateChg);

  p_rst_evt_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    rstEvt |=> (pwrState == S_RST && gateReq == '0));

  p_req_wait_ack_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (pwrState == S_REQ && !gateAck && !rstEvt) |=> (pwrState == S_REQ));

  p_fw_wait_ack_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (pwrState == S_FW && gateAck && !rstEvt) |=> (pwrState == S_FW));

  p_sleep_hold_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    ((pwrState == S_LOW || pwrState == S_DEEP) && wakeSrc == '0 && !rstEvt)
      |=> $stable(pwrState));

  p_active_ignores_wake_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (pwrState == S_ACT && !lpReq && !rstEvt) |=> (pwrState == S_ACT));
endmodule

bind lpm_seq_top lpm_seq_chk #(.NUM_WAKE(NUM_WAKE), .NUM_DOM(NUM_DOM)) chk_i (
  .clk(clk), .rst_ni(rst_ni), .lpReq(lpReq), .wakeSrc(wakeSrc),
  .gateAck(gateAck), .rstEvt(rstEvt), .pwrState(pwrState),
  .stateChg(stateChg), .gateReq(gateReq)
);

// File: tb/lpm_seq_top_tb_top.sv
module lpm_seq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lpReq = 1'b0;
  logic       deepSel = 1'b0;
  logic [2:0] wakeSrc = 3'b000;
  logic       gateAck = 1'b0;
  logic       rstEvt = 1'b0;
  logic [2:0] pwrState;
  logic       stateChg;
  logic [2:0] gateReq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lpm_seq_top dut_i (
    .clk(clk), .rst_ni(rst_ni), .lpReq(lpReq), .deepSel(deepSel),
    .wakeSrc(wakeSrc), .gateAck(gateAck), .rstEvt(rstEvt),
    .pwrState(pwrState), .stateChg(stateChg), .gateReq(gateReq)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expect3(string req, logic [2:0] st, logic chg, logic [2:0] g);
    checks++;
    if (pwrState !== st || stateChg !== chg || gateReq !== g) begin
      failures++;
      $display("FAIL %s: state=%0d chg=%0b gate=%b expected state=%0d chg=%0b gate=%b",
               req, pwrState, stateChg, gateReq, st, chg, g);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    tick(); tick();
    expect3("R1 in reset", 3'd0, 1'b0, 3'b000);
    rst_ni = 1'b1;
    tick();
    expect3("R1 leave reset", 3'd1, 1'b1, 3'b000);
    tick();
    expect3("R7 no pulse when steady", 3'd1, 1'b0, 3'b000);
  endtask

  task automatic t_sleep(bit deep, int wakeBit);
    logic [2:0] slp;
    slp = deep ? 3'd4 : 3'd3;
    deepSel = deep;
    lpReq = 1'b1;
    tick();
    expect3("R2 request accepted", 3'd2, 1'b1, 3'b111);
    lpReq = 1'b0;
    deepSel = !deep;
    tick(); tick();
    expect3("R3 wait gate ack", 3'd2, 1'b0, 3'b111);
    gateAck = 1'b1;
    tick();
    expect3("R4 sleep state chosen at request", slp, 1'b1, 3'b111);
    tick(); tick();
    expect3("R5 sleep holds", slp, 1'b0, 3'b111);
    wakeSrc[wakeBit] = 1'b1;
    tick();
    expect3("R5 R6 wake to fast wake", 3'd5, 1'b1, 3'b000);
    wakeSrc = '0;
    tick(); tick();
    expect3("R6 wait ungate ack", 3'd5, 1'b0, 3'b000);
    gateAck = 1'b0;
    tick();
    expect3("R6 back to active", 3'd1, 1'b1, 3'b000);
    tick();
  endtask

  task automatic t_ignore();
    wakeSrc = 3'b111;
    tick();
    expect3("R10 wake in active ignored", 3'd1, 1'b0, 3'b000);
    wakeSrc = '0;
    deepSel = 1'b0;
    lpReq = 1'b1;
    tick();
    expect3("R2 request", 3'd2, 1'b1, 3'b111);
    wakeSrc = 3'b111;
    tick();
    expect3("R9 R10 request state ignores lpReq and wake", 3'd2, 1'b0, 3'b111);
    wakeSrc = '0;
    gateAck = 1'b1;
    tick();
    expect3("R3 enter low power", 3'd3, 1'b1, 3'b111);
    tick();
    expect3("R9 lpReq in low power ignored", 3'd3, 1'b0, 3'b111);
    wakeSrc = 3'b001;
    tick();
    expect3("R6 fast wake", 3'd5, 1'b1, 3'b000);
    wakeSrc = '0;
    tick();
    expect3("R9 lpReq in fast wake ignored", 3'd5, 1'b0, 3'b000);
    lpReq = 1'b0;
    gateAck = 1'b0;
    tick();
    expect3("R6 active again", 3'd1, 1'b1, 3'b000);
    tick();
  endtask

  task automatic t_rst_evt();
    deepSel = 1'b1;
    lpReq = 1'b1;
    tick();
    lpReq = 1'b0;
    gateAck = 1'b1;
    tick();
    expect3("R3 deep sleep", 3'd4, 1'b1, 3'b111);
    rstEvt = 1'b1;
    tick();
    expect3("R8 reset event from sleep", 3'd0, 1'b1, 3'b000);
    tick();
    expect3("R8 held reset event", 3'd0, 1'b0, 3'b000);
    rstEvt = 1'b0;
    gateAck = 1'b0;
    tick();
    expect3("R8 resume active", 3'd1, 1'b1, 3'b000);
    lpReq = 1'b1;
    tick();
    lpReq = 1'b0;
    rstEvt = 1'b1;
    tick();
    expect3("R8 reset event from request", 3'd0, 1'b1, 3'b000);
    rstEvt = 1'b0;
    tick();
    expect3("R1 R8 active after event", 3'd1, 1'b1, 3'b000);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sleep(1'b0, 0);
    t_sleep(1'b1, 1);
    t_sleep(1'b0, 2);
    t_ignore();
    t_rst_evt();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule